// File: doc/BRIEF.md
# Standby Mode Sequencer

This block moves a processor core between run operation and three standby levels: sleep, timer and stop. Software asks for standby by pulsing a wait strobe. Two inputs qualify the strobe: a deep-standby bit and a two-bit standby-type field. While the core is in standby, the block drives the clock enables for the CPU, the AHB fabric, three APB segments and the oscillators. Each standby level has its own set of clocks that it gates.

Reset and interrupt requests from the rest of the chip arrive as plain bit vectors. Each standby level accepts only a subset of them as wake events. An accepted interrupt returns the core to the clock source that was active when it entered standby. An accepted reset always lands on the fast RC source, after the RC oscillators report that they are stable. Leaving stop mode, or leaving timer mode while running from the slow RC or sub oscillator, first passes through a regulator settling window of a parameterised length. All clock enables stay low during that window.

Top module: `stby_ctrl`

## Requirements
- R1: After `rst_n` is released, `pm_mode` is 0 (run) and `resume_src` is 000. In run, `cpu_en`, `ahb_en`, `apb0_en` and `osc_en` are 1, and `apb1_en`/`apb2_en` equal `apb1_cfg`/`apb2_cfg`.
- R2: In run, with no reset request, a `wait_req` sampled at a clock edge moves `pm_mode` at that edge. With `deep_sel`=0 it goes to 1 (sleep). With `deep_sel`=1 and `stby_type`=00 it goes to 2 (timer). With `deep_sel`=1 and `stby_type`=10 it goes to 3 (stop). With `deep_sel`=1 and `stby_type` 01 or 11 the request is ignored and the mode stays 0.
- R3: In sleep, `cpu_en` is 0, `ahb_en`, `apb0_en` and `osc_en` are 1, and `apb1_en`/`apb2_en` follow their config inputs.
- R4: In timer (2), all five bus enables are 0 and `osc_en` is 1. In stop (3), all six enables are 0. In settle (4) and RC-wait (5), all five bus enables are 0 and `osc_en` is 1.
- R5: In sleep, any set bit of `irq_req` wakes the core. The wake takes effect at the next edge. `resume_src` then equals the `cur_src` value sampled when standby was entered.
- R6: In timer, only `irq_req` bits 0 to 5 wake the core: NMI, external, USB wake, low voltage, hardware watchdog and watch counter. Bit 6, the generic peripheral interrupt, is ignored.
- R7: In stop, only `irq_req` bits 0 to 3 wake the core.
- R8: Reset wake sets per mode. Sleep accepts `rst_req` bits 0 to 5: pin, low voltage, hardware watchdog, clock failure, software watchdog and abnormal frequency. Timer accepts bits 0 to 3. Stop accepts bits 0 and 1. In run, any set bit of `rst_req` moves the core to RC-wait.
- R9: An accepted reset leads to RC-wait (5), directly or through settle. RC-wait holds until `rc_stable` is sampled high. The next mode is then run, with `resume_src` = 000.
- R10: Certain wakes pass through settle (4): any wake from stop, and any wake from timer when the captured source is 100 (slow RC) or 101 (sub). Settle lasts exactly `SETTLE_CYC` cycles. It then moves to run if the wake was an interrupt, and to RC-wait if the wake was a reset or if any `rst_req` bit was seen during settle. Wakes from timer with any other source skip settle.
- R11: When an accepted reset and an accepted interrupt arrive in the same cycle, the reset path is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| wait_req | input | 1 | Wait-for-interrupt/event strobe from the core |
| deep_sel | input | 1 | Deep-standby qualifier |
| stby_type | input | 2 | Deep standby type: 00 timer, 10 stop, others reserved |
| cur_src | input | 3 | Active clock source: 000 fast RC, 001 main, 010 PLL, 100 slow RC, 101 sub |
| apb1_cfg | input | 1 | APB1 enable setting used in run and sleep |
| apb2_cfg | input | 1 | APB2 enable setting used in run and sleep |
| irq_req | input | 7 | Interrupt requests: 0 NMI, 1 external, 2 USB wake, 3 low voltage, 4 HW watchdog, 5 watch counter, 6 peripheral |
| rst_req | input | 6 | Reset requests: 0 pin, 1 low voltage, 2 HW watchdog, 3 clock failure, 4 SW watchdog, 5 abnormal frequency |
| rc_stable | input | 1 | RC oscillators report stable |
| pm_mode | output | 3 | 0 run, 1 sleep, 2 timer, 3 stop, 4 settle, 5 RC-wait |
| resume_src | output | 3 | Clock source the core resumes on |
| cpu_en | output | 1 | CPU clock enable |
| ahb_en | output | 1 | AHB clock enable |
| apb0_en | output | 1 | APB0 clock enable |
| apb1_en | output | 1 | APB1 clock enable |
| apb2_en | output | 1 | APB2 clock enable |
| osc_en | output | 1 | Oscillator run enable |

## Verification
The bench targets four corner cases:
- Wake sources that sit just outside a level's accepted set, such as peripheral interrupt bit 6 in timer mode or the software-watchdog reset in stop mode. A filter that is too wide would wake the core early.
- The same-cycle collision of a reset and an interrupt. A design with the priority reversed would resume on the old clock source instead of fast RC.
- The exact length of the settle window, and a reset that arrives inside it. An off-by-one counter shifts the return by a cycle, and a lost reset flag returns to run instead of RC-wait.
- Reserved standby types. These must leave every clock running.

// File: rtl/stby_pkg.sv
package stby_pkg;

  localparam int IRQ_W = 7;
  localparam int RST_W = 6;

  typedef enum logic [2:0] {
    PM_RUN    = 3'd0,
    PM_SLEEP  = 3'd1,
    PM_TIMER  = 3'd2,
    PM_STOP   = 3'd3,
    PM_SETTLE = 3'd4,
    PM_RCWAIT = 3'd5
  } pm_state_e;

  localparam logic [2:0] SRC_FRC  = 3'b000;
  localparam logic [2:0] SRC_SLOW = 3'b100;
  localparam logic [2:0] SRC_SUB  = 3'b101;

  typedef struct packed {
    logic osc;
    logic apb2;
    logic apb1;
    logic apb0;
    logic ahb;
    logic cpu;
  } clk_en_t;

  // Interrupts able to end each standby level
  function automatic logic [IRQ_W-1:0] irq_mask_f(pm_state_e s);
    case (s)
      PM_SLEEP: irq_mask_f = 7'b111_1111;
      PM_TIMER: irq_mask_f = 7'b011_1111;
      PM_STOP:  irq_mask_f = 7'b000_1111;
      default:  irq_mask_f = '0;
    endcase
  endfunction

  // Reset requests honoured in each state
  function automatic logic [RST_W-1:0] rst_mask_f(pm_state_e s);
    case (s)
      PM_RUN, PM_SLEEP, PM_SETTLE: rst_mask_f = 6'b11_1111;
      PM_TIMER: rst_mask_f = 6'b00_1111;
      PM_STOP:  rst_mask_f = 6'b00_0011;
      default:  rst_mask_f = '0;
    endcase
  endfunction

  function automatic logic needs_settle_f(pm_state_e s, logic [2:0] src);
    needs_settle_f = (s == PM_STOP) ||
                     ((s == PM_TIMER) && ((src == SRC_SLOW) || (src == SRC_SUB)));
  endfunction

  function automatic clk_en_t clk_en_f(pm_state_e s, logic a1, logic a2);
    clk_en_t e;
    e = '0;
    case (s)
      PM_RUN: begin
        e.cpu = 1'b1; e.ahb = 1'b1; e.apb0 = 1'b1;
        e.apb1 = a1;  e.apb2 = a2;  e.osc = 1'b1;
      end
      PM_SLEEP: begin
        e.ahb = 1'b1; e.apb0 = 1'b1;
        e.apb1 = a1;  e.apb2 = a2;  e.osc = 1'b1;
      end
      PM_STOP: e = '0;
      default: e.osc = 1'b1;
    endcase
    return e;
  endfunction

  // Decode a wait strobe into a standby target; reserved types map to run
  function automatic pm_state_e entry_target_f(logic deep, logic [1:0] ty);
    if (!deep)            entry_target_f = PM_SLEEP;
    else if (ty == 2'b00) entry_target_f = PM_TIMER;
    else if (ty == 2'b10) entry_target_f = PM_STOP;
    else                  entry_target_f = PM_RUN;
  endfunction

endpackage

// File: rtl/stby_entry_dec.sv
module stby_entry_dec
  import stby_pkg::*;
(
  input  logic       wait_req,
  input  logic       deep_sel,
  input  logic [1:0] stby_type,
  output logic       enter,
  output pm_state_e  target
);
  always_comb begin
    target = entry_target_f(deep_sel, stby_type);
    enter  = wait_req && (target != PM_RUN);
  end
endmodule

// File: rtl/stby_wake_filter.sv
module stby_wake_filter
  import stby_pkg::*;
(
  input  pm_state_e        state,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic [RST_W-1:0] rst_req,
  output logic             irq_hit,
  output logic             rst_hit
);
  logic [IRQ_W-1:0] irq_ok;
  logic [RST_W-1:0] rst_ok;

  always_comb begin
    irq_ok  = irq_req & irq_mask_f(state);
    rst_ok  = rst_req & rst_mask_f(state);
    irq_hit = |irq_ok;
    rst_hit = |rst_ok;
  end
endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic done
);
  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (start)                 cnt_q <= LOAD;
    else if (active && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = active && (cnt_q == '0);

  // R10
  settle_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R10
  settle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == LOAD));
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_req,
  input  logic       deep_sel,
  input  logic [1:0] stby_type,
  input  logic [2:0] cur_src,
  input  logic       apb1_cfg,
  input  logic       apb2_cfg,
  input  logic [6:0] irq_req,
  input  logic [5:0] rst_req,
  input  logic       rc_stable,
  output logic [2:0] pm_mode,
  output logic [2:0] resume_src,
  output logic       cpu_en,
  output logic       ahb_en,
  output logic       apb0_en,
  output logic       apb1_en,
  output logic       apb2_en,
  output logic       osc_en
);
  pm_state_e  state_q, state_n;
  logic [2:0] src_q, src_n;
  logic       rv_q, rv_n;

  logic       enter;
  pm_state_e  target;
  logic       irq_hit, rst_hit;
  logic       settle_start, settle_done, settle_act;
  logic       settle_need;
  clk_en_t    en;

  stby_entry_dec u_dec (
    .wait_req (wait_req),
    .deep_sel (deep_sel),
    .stby_type(stby_type),
    .enter    (enter),
    .target   (target)
  );

  stby_wake_filter u_wake (
    .state  (state_q),
    .irq_req(irq_req),
    .rst_req(rst_req),
    .irq_hit(irq_hit),
    .rst_hit(rst_hit)
  );

  assign settle_act  = (state_q == PM_SETTLE);
  assign settle_need = needs_settle_f(state_q, src_q);

  stby_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (settle_start),
    .active(settle_act),
    .done  (settle_done)
  );

  always_comb begin
    state_n      = state_q;
    src_n        = src_q;
    rv_n         = rv_q;
    settle_start = 1'b0;
    case (state_q)
      PM_RUN: begin
        if (rst_hit) begin
          state_n = PM_RCWAIT;
        end else if (enter) begin
          state_n = target;
          src_n   = cur_src;
        end
      end
      PM_SLEEP, PM_TIMER, PM_STOP: begin
        if (rst_hit || irq_hit) begin
          if (settle_need) begin
            state_n      = PM_SETTLE;
            settle_start = 1'b1;
            rv_n         = rst_hit;
          end else begin
            state_n = rst_hit ? PM_RCWAIT : PM_RUN;
          end
        end
      end
      PM_SETTLE: begin
        if (rst_hit) rv_n = 1'b1;
        if (settle_done) state_n = (rv_q || rst_hit) ? PM_RCWAIT : PM_RUN;
      end
      PM_RCWAIT: begin
        if (rc_stable) begin
          state_n = PM_RUN;
          src_n   = SRC_FRC;
        end
      end
      default: state_n = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      src_q   <= SRC_FRC;
      rv_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      src_q   <= src_n;
      rv_q    <= rv_n;
    end
  end

  always_comb en = clk_en_f(state_q, apb1_cfg, apb2_cfg);

  assign pm_mode    = state_q;
  assign resume_src = src_q;
  assign cpu_en     = en.cpu;
  assign ahb_en     = en.ahb;
  assign apb0_en    = en.apb0;
  assign apb1_en    = en.apb1;
  assign apb2_en    = en.apb2;
  assign osc_en     = en.osc;

  // R2
  rsvd_type_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && wait_req && deep_sel && stby_type[0] && rst_req == '0)
      |=> (pm_mode == 3'd0));

  // R3
  sleep_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 3'd1) |-> (!cpu_en && ahb_en && apb0_en && osc_en));

  // R4
  stop_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 3'd3) |-> !(cpu_en || ahb_en || apb0_en || apb1_en || apb2_en || osc_en));

  // R5
  sleep_irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SLEEP && irq_req != '0 && rst_req == '0)
      |=> (pm_mode == 3'd0 && $stable(resume_src)));

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_STOP && irq_req[3:0] == '0 && rst_req[1:0] == '0)
      |=> (pm_mode == 3'd3));

  // R9
  rcwait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RCWAIT && rc_stable) |=> (pm_mode == 3'd0 && resume_src == 3'b000));

  // R11
  rst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SLEEP && rst_req != '0 && irq_req != '0) |=> (pm_mode == 3'd5));
endmodule

// File: tb/stby_ctrl_tb.sv
module stby_ctrl_tb;
  localparam int SETTLE = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wait_req = 0, deep_sel = 0;
  logic [1:0] stby_type = 0;
  logic [2:0] cur_src = 0;
  logic       apb1_cfg = 1, apb2_cfg = 0;
  logic [6:0] irq_req = 0;
  logic [5:0] rst_req = 0;
  logic       rc_stable = 0;
  logic [2:0] pm_mode, resume_src;
  logic       cpu_en, ahb_en, apb0_en, apb1_en, apb2_en, osc_en;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  stby_ctrl #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .deep_sel(deep_sel),
    .stby_type(stby_type), .cur_src(cur_src), .apb1_cfg(apb1_cfg), .apb2_cfg(apb2_cfg),
    .irq_req(irq_req), .rst_req(rst_req), .rc_stable(rc_stable),
    .pm_mode(pm_mode), .resume_src(resume_src), .cpu_en(cpu_en), .ahb_en(ahb_en),
    .apb0_en(apb0_en), .apb1_en(apb1_en), .apb2_en(apb2_en), .osc_en(osc_en));

  // Reference model state
  int         m_mode = 0;
  logic [2:0] m_src = 0;
  int         m_cnt = 0;
  bit         m_rv = 0;
  string      m_tag = "R1";

  function automatic logic [6:0] m_irq_set(int md);
    if (md == 1) return 7'h7f;
    if (md == 2) return 7'h3f;
    if (md == 3) return 7'h0f;
    return 7'h00;
  endfunction

  function automatic logic [5:0] m_rst_set(int md);
    if (md == 0 || md == 1 || md == 4) return 6'h3f;
    if (md == 2) return 6'h0f;
    if (md == 3) return 6'h03;
    return 6'h00;
  endfunction

  function automatic logic [5:0] m_enables(int md, logic a1, logic a2);
    // order: osc apb2 apb1 apb0 ahb cpu
    case (md)
      0: return {1'b1, a2, a1, 1'b1, 1'b1, 1'b1};
      1: return {1'b1, a2, a1, 1'b1, 1'b1, 1'b0};
      3: return 6'b000000;
      default: return 6'b100000;
    endcase
  endfunction

  task automatic model_step();
    bit r, q, slowish;
    r = |(rst_req & m_rst_set(m_mode));
    q = |(irq_req & m_irq_set(m_mode));
    case (m_mode)
      0: begin
        if (r) begin m_mode = 5; m_tag = "R8"; end
        else if (wait_req) begin
          m_tag = "R2";
          if (!deep_sel) begin m_mode = 1; m_src = cur_src; end
          else if (stby_type == 2'b00) begin m_mode = 2; m_src = cur_src; end
          else if (stby_type == 2'b10) begin m_mode = 3; m_src = cur_src; end
        end else m_tag = "R1";
      end
      1, 2, 3: begin
        slowish = (m_mode == 3) || (m_mode == 2 && (m_src == 3'b100 || m_src == 3'b101));
        m_tag = (m_mode == 1) ? "R5" : (m_mode == 2) ? "R6" : "R7";
        if (r && q) m_tag = "R11";
        else if (r) m_tag = "R8";
        if (r || q) begin
          if (slowish) begin m_mode = 4; m_cnt = SETTLE - 1; m_rv = r; m_tag = "R10"; end
          else m_mode = r ? 5 : 0;
        end
      end
      4: begin
        m_tag = "R10";
        if (r) m_rv = 1;
        if (m_cnt == 0) m_mode = m_rv ? 5 : 0;
        else m_cnt = m_cnt - 1;
      end
      default: begin
        m_tag = "R9";
        if (rc_stable) begin m_mode = 0; m_src = 3'b000; end
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin m_mode = 0; m_src = 0; m_cnt = 0; m_rv = 0; m_tag = "R1"; end
    else model_step();
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string etag;
    logic [5:0] e;
    etag = (m_mode == 0) ? "R1" : (m_mode == 1) ? "R3" : "R4";
    e = m_enables(m_mode, apb1_cfg, apb2_cfg);
    chk(m_tag, pm_mode, m_mode, "mode");
    chk(m_tag, resume_src, m_src, "resume_src");
    chk(etag, {osc_en, apb2_en, apb1_en, apb0_en, ahb_en, cpu_en}, e, "clock enables");
  endtask

  task automatic drive(logic w, logic d, logic [1:0] t, logic [6:0] iq, logic [5:0] rq, logic rc);
    wait_req = w; deep_sel = d; stby_type = t; irq_req = iq; rst_req = rq; rc_stable = rc;
  endtask

  // one cycle: inputs set at negedge, edge, then check at next negedge
  task automatic cyc(logic w, logic d, logic [1:0] t, logic [6:0] iq, logic [5:0] rq, logic rc);
    drive(w, d, t, iq, rq, rc);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #400000;
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all(); // R1 reset state
    chk("R1", pm_mode, 0, "reset mode");

    // R2 reserved types ignored
    cyc(1, 1, 2'b01, 0, 0, 0);
    chk("R2", pm_mode, 0, "reserved 01");
    cyc(1, 1, 2'b11, 0, 0, 0);
    chk("R2", pm_mode, 0, "reserved 11");

    // R6 timer from PLL ignores bit 6, wakes on watch counter without settle
    cur_src = 3'b010;
    cyc(1, 1, 2'b00, 0, 0, 0);
    cyc(0, 0, 0, 7'h40, 6'h30, 0);
    chk("R6", pm_mode, 2, "timer ignores irq6/sw rst");
    cyc(0, 0, 0, 7'h20, 0, 0);
    chk("R6", pm_mode, 0, "timer wake");
    chk("R5", resume_src, 3'b010, "resume PLL");

    // R10 stop wake via interrupt: settle then run
    cur_src = 3'b001;
    cyc(1, 1, 2'b10, 0, 0, 0);
    cyc(0, 0, 0, 7'h70, 6'h3c, 0);
    chk("R7", pm_mode, 3, "stop ignores high sources");
    cyc(0, 0, 0, 7'h01, 0, 0);
    for (int i = 0; i < SETTLE - 1; i++) cyc(0, 0, 0, 0, 0, 0);
    chk("R10", pm_mode, 4, "settle last cycle");
    cyc(0, 0, 0, 0, 0, 0);
    chk("R10", pm_mode, 0, "settle exit");

    // R11 reset and interrupt together in sleep
    cur_src = 3'b101;
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 7'h40, 6'h10, 0);
    chk("R11", pm_mode, 5, "reset first");
    cyc(0, 0, 0, 0, 0, 1);
    chk("R9", resume_src, 3'b000, "fast RC after reset");

    // R10 reset during settle from sub timer
    cur_src = 3'b101;
    cyc(1, 1, 2'b00, 0, 0, 0);
    cyc(0, 0, 0, 7'h02, 0, 0);
    cyc(0, 0, 0, 0, 6'h01, 0);
    for (int i = 0; i < SETTLE - 1; i++) cyc(0, 0, 0, 0, 0, 0);
    chk("R10", pm_mode, 5, "settle ends in rc wait");
    cyc(0, 0, 0, 0, 0, 1);

    // Random phase
    for (int n = 0; n < 6000; n++) begin
      logic [6:0] iq;
      logic [5:0] rq;
      iq = '0; rq = '0;
      if ($urandom_range(0, 5) == 0) iq = 7'(1 << $urandom_range(0, 6));
      if ($urandom_range(0, 29) == 0) rq = 6'(1 << $urandom_range(0, 5));
      if ($urandom_range(0, 15) == 0) cur_src = ($urandom_range(0, 1) != 0) ?
          3'($urandom_range(0, 2)) : 3'($urandom_range(4, 5));
      if ($urandom_range(0, 40) == 0) begin
        apb1_cfg = 1'($urandom); apb2_cfg = 1'($urandom);
      end
      cyc(1'($urandom_range(0, 3) == 0), 1'($urandom), 2'($urandom),
          iq, rq, 1'($urandom_range(0, 2) == 0));
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule